// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host end of a two-wire debug link. It generates the serial clock and runs one complete register transaction at a time over a single data line that the host and the target share. The caller sets the port (access port or debug port), the direction, a 2-bit register index and, for writes, a 32-bit word, and then pulses `start`. The engine sends an 8-bit request header and releases the line for a turnaround cycle. It collects the target's 3-bit reply and then either moves a 32-bit word with its parity bit or stops early.

When the transaction ends, the engine pulses `done` and reports the reply code. On reads it also returns the received word and flags a parity mismatch. The serial clock period is set at run time as a number of system clock cycles per half period. Line reset sequences and retrying after a busy reply are left to the caller.

Top module: `swd_host_engine`

## Requirements
- R1: The request header goes out first bit first in this order: start=1, port (1=access port), direction (1=read), reg_addr[0], reg_addr[1], even parity over the four preceding bits, stop=0, park=1. The host drives the line for all eight bits.
- R2: The host releases the line (`swdio_oe`=0) for the one turnaround bit that follows the request. It keeps the line released for all three reply bits.
- R3: The 3-bit reply is taken least significant bit first and is reported on `ack` at the end of the transaction. The codes are 3'b001 (OK), 3'b010 (WAIT) and 3'b100 (FAULT). Any other value is a protocol error.
- R4: A write with an OK reply takes one more turnaround bit with the line released. The host then drives 32 data bits, least significant first, followed by even parity over them. The whole write takes 46 serial clock cycles.
- R5: A read with an OK reply captures 32 bits least significant first, then a parity bit, then one turnaround bit, and presents the word on `rdata`. The whole read takes 46 serial clock cycles.
- R6: `parity_err` is set only when a read with an OK reply receives a parity bit that makes the 33 bits odd. Otherwise it is 0 after the transaction.
- R7: A reply other than OK skips the data phase. The transaction ends after one turnaround bit, 13 serial clock cycles in total, and `rdata` keeps its earlier value.
- R8: Each serial clock half period lasts `clk_div`+1 system clock cycles, so a transaction of N bits ends exactly 2·(`clk_div`+1)·N system cycles after `start` is taken. `swclk` is low while idle. The host changes `swdio_out` and `swdio_oe` only while `swclk` is low, and samples `swdio_in` on its rising edges.
- R9: `busy` is high from the cycle after `start` is accepted until the cycle in which `done` pulses for exactly one cycle. While `busy` is high, `start` and its fields are ignored.
- R10: After reset `busy`, `done`, `swclk`, `swdio_oe`, `parity_err`, `ack` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | DIV_W | Serial half period minus one, in system cycles; must be stable while busy |
| start | input | 1 | Begin a transaction (taken only when idle) |
| port_ap | input | 1 | 1 = access port, 0 = debug port |
| is_read | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 2 | Register index, bit 0 sent first |
| wdata | input | 32 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| ack | output | 3 | Reply code of the last transaction |
| rdata | output | 32 | Word from the last successful read |
| parity_err | output | 1 | Parity mismatch on the last read |
| swclk | output | 1 | Serial clock to the target |
| swdio_out | output | 1 | Data driven by the host |
| swdio_oe | output | 1 | Host drive enable for the data line |
| swdio_in | input | 1 | Data line value seen by the host |

## Verification
The hardest case to reach is a `start` pulse that arrives mid-transaction with different port and direction fields. It must change neither the header already being sent nor the branch taken after the reply. The stimulus raises `start` well inside the data phase and checks that the target model still decodes the original header and sees only one transaction. A behavioural target model in the bench answers with OK, WAIT, FAULT and invalid codes, sometimes with a corrupted read parity bit. This drives every branch after the reply at several divider settings.

// File: rtl/swd_host_pkg.sv
// Package: shared types, reply codes and helper functions for the debug host engine.
// Assumes a fixed 32-bit data word as the link protocol defines.
package swd_host_pkg;
    localparam int DATA_W = 32;
    localparam int REQ_W  = 8;
    localparam int ACK_W  = 3;
    localparam int BIT_W  = $clog2(DATA_W + 1);

    localparam logic [ACK_W-1:0] REPLY_OK    = 3'b001;
    localparam logic [ACK_W-1:0] REPLY_WAIT  = 3'b010;
    localparam logic [ACK_W-1:0] REPLY_FAULT = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_TURN_REQ,
        PH_REPLY,
        PH_TURN_WR,
        PH_WDATA,
        PH_RDATA,
        PH_TURN_END
    } phase_t;

    // Build the 8-bit header, index 0 goes on the wire first.
    function automatic logic [REQ_W-1:0] make_header(input logic ap, input logic rd,
                                                     input logic [1:0] a);
        logic par;
        par = ap ^ rd ^ a[0] ^ a[1];
        return {1'b1, 1'b0, par, a[1], a[0], rd, ap, 1'b1};
    endfunction

    // Index of the last bit in each phase.
    function automatic logic [BIT_W-1:0] phase_last(input phase_t ph);
        case (ph)
            PH_REQ:   return BIT_W'(REQ_W - 1);
            PH_REPLY: return BIT_W'(ACK_W - 1);
            PH_WDATA,
            PH_RDATA: return BIT_W'(DATA_W);
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/swd_tick_gen.sv
// Serial clock generator. Holds swclk low while idle and latches the divider
// when idle. Each half period lasts div+1 cycles. Flags the system edge at
// which swclk rises or falls. Assumes run stays high for a whole transaction.
module swd_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             swclk,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic             hit;

    assign hit      = run && (cnt_q == div_q);
    assign rise_evt = hit && !sclk_q;
    assign fall_evt = hit && sclk_q;
    assign swclk    = sclk_q;

    // Half-period counter and clock level; divider captured while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            div_q  <= '0;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            div_q  <= div_in;
        end else if (hit) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= div_q);
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(div_q));
endmodule

// File: rtl/swd_seq.sv
// Transaction sequencer. It steps through header, turnaround, reply and data
// phases, shifting out on serial falling edges and sampling in on rising ones.
// Assumes rise_evt and fall_evt alternate and come from swd_tick_gen.
module swd_seq
    import swd_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              port_ap,
    input  logic              is_read,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              swdio_in,
    output logic              busy,
    output logic              done,
    output logic [ACK_W-1:0]  ack,
    output logic [DATA_W-1:0] rdata,
    output logic              parity_err,
    output logic              swdio_out,
    output logic              swdio_oe
);
    phase_t            ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W:0]   tx_q;
    logic [DATA_W:0]   rx_q;
    logic [ACK_W-1:0]  reply_q;
    logic [DATA_W-1:0] wd_q;
    logic              rd_q;
    logic              last_bit;

    assign last_bit  = (bit_q == phase_last(ph_q));
    assign busy      = (ph_q != PH_IDLE);
    assign swdio_oe  = (ph_q == PH_REQ) || (ph_q == PH_WDATA);
    assign swdio_out = swdio_oe & tx_q[0];

    // Phase control, shifters and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            bit_q      <= '0;
            tx_q       <= '0;
            rx_q       <= '0;
            reply_q    <= '0;
            wd_q       <= '0;
            rd_q       <= 1'b0;
            done       <= 1'b0;
            ack        <= '0;
            rdata      <= '0;
            parity_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ph_q == PH_IDLE) begin
                if (start) begin
                    tx_q       <= {{(DATA_W + 1 - REQ_W){1'b0}},
                                   make_header(port_ap, is_read, reg_addr)};
                    rd_q       <= is_read;
                    wd_q       <= wdata;
                    parity_err <= 1'b0;
                    bit_q      <= '0;
                    ph_q       <= PH_REQ;
                end
            end else begin
                if (rise_evt && ph_q == PH_REPLY)
                    reply_q <= {swdio_in, reply_q[ACK_W-1:1]};
                if (rise_evt && ph_q == PH_RDATA)
                    rx_q <= {swdio_in, rx_q[DATA_W:1]};
                if (fall_evt) begin
                    if (ph_q == PH_REQ || ph_q == PH_WDATA)
                        tx_q <= tx_q >> 1;
                    if (!last_bit) begin
                        bit_q <= bit_q + 1'b1;
                    end else begin
                        bit_q <= '0;
                        case (ph_q)
                            PH_REQ:      ph_q <= PH_TURN_REQ;
                            PH_TURN_REQ: ph_q <= PH_REPLY;
                            PH_REPLY: begin
                                ack <= reply_q;
                                if (reply_q == REPLY_OK)
                                    ph_q <= rd_q ? PH_RDATA : PH_TURN_WR;
                                else
                                    ph_q <= PH_TURN_END;
                            end
                            PH_TURN_WR: begin
                                tx_q <= {^wd_q, wd_q};
                                ph_q <= PH_WDATA;
                            end
                            PH_RDATA: begin
                                rdata      <= rx_q[DATA_W-1:0];
                                parity_err <= ^rx_q;
                                ph_q       <= PH_TURN_END;
                            end
                            default: begin
                                ph_q <= PH_IDLE;
                                done <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fall_evt));
    p_dir_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(rd_q) && $stable(wd_q)));
    p_perr_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> (rd_q && ack == REPLY_OK));
    p_released_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ph_q) == PH_REQ && ph_q == PH_TURN_REQ) |-> !swdio_oe);
endmodule

// File: rtl/swd_host_engine.sv
// Top: serial debug host engine. Connects the clock generator to the
// sequencer. Assumes clk_div is held stable while busy.
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              start,
    input  logic              port_ap,
    input  logic              is_read,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       wdata,
    output logic              busy,
    output logic              done,
    output logic [2:0]        ack,
    output logic [31:0]       rdata,
    output logic              parity_err,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    logic rise_evt;
    logic fall_evt;

    swd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div_in   (clk_div),
        .swclk    (swclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    swd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .port_ap    (port_ap),
        .is_read    (is_read),
        .reg_addr   (reg_addr),
        .wdata      (wdata),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt),
        .swdio_in   (swdio_in),
        .busy       (busy),
        .done       (done),
        .ack        (ack),
        .rdata      (rdata),
        .parity_err (parity_err),
        .swdio_out  (swdio_out),
        .swdio_oe   (swdio_oe)
    );

    p_drive_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));
    p_idle_clk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !swclk);
endmodule

// File: tb/swd_host_engine_tb.sv
// Bench: a behavioural target answers on the shared line; each transaction is
// checked against expectations computed from the requirements.
module swd_host_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] OK = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = '0;
    logic        start = 1'b0;
    logic        port_ap = 1'b0;
    logic        is_read = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] wdata = '0;
    logic        busy, done, parity_err, swclk, swdio_out, swdio_oe;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        swdio_in = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // target configuration, written by the stimulus only
    logic        cfg_rd = 0;
    logic [2:0]  cfg_ack = OK;
    logic [31:0] cfg_rdat = '0;
    logic        cfg_bad = 0;
    // target observations, written by the target model only
    int          rise_cnt = 0;
    int          oe_bad = 0;
    int          txn_seen = 0;
    logic [7:0]  req_cap = '0;
    logic [32:0] wcap = '0;
    logic        prev_sclk = 0;
    logic        prev_busy = 0;

    swd_host_engine u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start),
        .port_ap(port_ap), .is_read(is_read), .reg_addr(reg_addr), .wdata(wdata),
        .busy(busy), .done(done), .ack(ack), .rdata(rdata), .parity_err(parity_err),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] exp_header(input logic ap, input logic rd,
                                              input logic [1:0] a);
        return {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
    endfunction

    function automatic logic target_bit(input int i);
        if (i >= 9 && i <= 11) return cfg_ack[i - 9];
        if (cfg_rd && cfg_ack == OK && i >= 12 && i <= 43) return cfg_rdat[i - 12];
        if (cfg_rd && cfg_ack == OK && i == 44) return (^cfg_rdat) ^ cfg_bad;
        return 1'b1;
    endfunction

    function automatic logic host_drives(input int i);
        return (i < 8) || (!cfg_rd && cfg_ack == OK && i >= 13 && i <= 45);
    endfunction

    // Target model: sample the host on serial rising edges, drive between them.
    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            rise_cnt = 0;
            oe_bad   = 0;
            txn_seen = txn_seen + 1;
        end
        if (busy && swclk && !prev_sclk) begin
            if (swdio_oe !== host_drives(rise_cnt)) oe_bad = oe_bad + 1;
            if (rise_cnt < 8) req_cap[rise_cnt] = swdio_out;
            if (rise_cnt >= 13 && rise_cnt <= 45) wcap[rise_cnt - 13] = swdio_out;
            rise_cnt = rise_cnt + 1;
        end
        prev_sclk = swclk;
        prev_busy = busy;
        swdio_in  = target_bit(rise_cnt);
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [31:0] last_rdata = '0;

    task automatic run_txn(input logic ap, input logic rd, input logic [1:0] a,
                           input logic [31:0] wd, input logic [2:0] ackc,
                           input logic [31:0] rdd, input logic bad,
                           input logic [7:0] div, input bit inject);
        int k;
        int n;
        int seen_before;
        @(negedge clk);
        cfg_rd = rd; cfg_ack = ackc; cfg_rdat = rdd; cfg_bad = bad;
        clk_div = div; port_ap = ap; is_read = rd; reg_addr = a; wdata = wd;
        start = 1'b1;
        seen_before = txn_seen;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 20000) begin
            @(negedge clk);
            k++;
            if (inject && k == 60) begin
                start = 1'b1; port_ap = ~ap; is_read = ~rd; wdata = ~wd;
            end
            if (inject && k == 61) start = 1'b0;
        end
        n = (ackc == OK) ? 46 : 13;
        chk(k == 2 * (div + 1) * n, "R8 done latency", 64'(k), 64'(2 * (div + 1) * n));
        chk(rise_cnt == n, (ackc == OK) ? "R5 R4 cycle count" : "R7 short cycle count",
            64'(rise_cnt), 64'(n));
        chk(req_cap == exp_header(ap, rd, a), "R1 header", 64'(req_cap),
            64'(exp_header(ap, rd, a)));
        chk(oe_bad == 0, "R2 drive enable per bit", 64'(oe_bad), 64'd0);
        chk(ack == ackc, "R3 reply code", 64'(ack), 64'(ackc));
        if (ackc == OK && !rd)
            chk(wcap == {^wd, wd}, "R4 write data and parity", 64'(wcap), 64'({^wd, wd}));
        if (ackc == OK && rd) begin
            chk(rdata == rdd, "R5 read data", 64'(rdata), 64'(rdd));
            chk(parity_err == bad, "R6 parity flag", 64'(parity_err), 64'(bad));
            last_rdata = rdd;
        end else begin
            chk(parity_err == 1'b0, "R6 flag clear", 64'(parity_err), 64'd0);
            chk(rdata == last_rdata, "R7 rdata kept", 64'(rdata), 64'(last_rdata));
        end
        @(negedge clk);
        chk(!busy && !done && !swclk, "R9 idle after done",
            64'({busy, done, swclk}), 64'd0);
        if (inject) begin
            repeat (10) @(negedge clk);
            chk(!busy && txn_seen == seen_before + 1, "R9 start ignored while busy",
                64'(txn_seen - seen_before), 64'd1);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk({busy, done, swclk, swdio_oe, parity_err} == 5'b0 && ack == 3'b0 && rdata == 32'b0,
            "R10 reset state", 64'({busy, done, swclk, swdio_oe, parity_err}), 64'd0);
        rst_n = 1'b1;
        // directed corner cases
        run_txn(1, 0, 2'b01, 32'hA5C3_0F1E, OK,     32'h0,          0, 8'd0, 0);
        run_txn(0, 1, 2'b10, 32'h0,         OK,     32'h1234_5678,  0, 8'd1, 0);
        run_txn(1, 1, 2'b11, 32'h0,         OK,     32'hFFFF_0001,  1, 8'd0, 0);
        run_txn(0, 1, 2'b00, 32'h0,         3'b010, 32'hDEAD_BEEF,  0, 8'd2, 0);
        run_txn(1, 0, 2'b10, 32'h5555_AAAA, 3'b100, 32'h0,          0, 8'd0, 0);
        run_txn(0, 1, 2'b01, 32'h0,         3'b000, 32'h0BAD_F00D,  0, 8'd3, 0);
        run_txn(1, 1, 2'b00, 32'h0,         3'b111, 32'h0,          0, 8'd1, 0);
        run_txn(0, 0, 2'b11, 32'h8000_0001, OK,     32'h0,          0, 8'd1, 1);
        // constrained random mix
        for (int i = 0; i < 24; i++) begin
            logic [2:0] codes [5];
            codes[0] = OK; codes[1] = 3'b010; codes[2] = 3'b100;
            codes[3] = 3'b011; codes[4] = OK;
            run_txn(1'($urandom), 1'($urandom), 2'($urandom), $urandom,
                    codes[$urandom % 5], $urandom, 1'($urandom % 4 == 0),
                    8'($urandom % 4), 0);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule